// File: doc/BRIEF.md
# Timer Compare Waveform Unit

This block is a 16-bit counter with two compare channels, A and B. Each channel drives one waveform pin and its enable flag. A clock-enable input `tick` advances the counter. Depending on the timer mode, the counter counts upward only, wrapping at its top value, or it counts up to the top value and then back down to zero. Each channel has a 2-bit output mode. This mode selects whether the channel owns its pin and, if so, how compare matches and the bottom of the count change the pin level.

Software programs the block through one write port. The port selects one of four targets: the control word, the compare value of channel A, the compare value of channel B, or the count itself. The control word holds the timer mode, both output modes and two force strobes. A force strobe applies a channel's compare action at once, without waiting for a match. It works only in the non-PWM modes. In the PWM modes, compare writes go to a holding register. That register is copied to the active compare value at a point in the count that depends on the mode, so a change never cuts a PWM period short. Each channel also emits a one-cycle flag on every compare match.

Top module: `tmr_cmp_wave`

## Requirements
- R1: After reset, `count` is 0, both pins are 0, both pin enables are 0 and both flags are 0. Timer mode is 0 and both output modes are 00.
- R2: Timer mode codes are as follows. 0 is free-running with top at all ones. 1 is clear-on-match with top equal to the A compare value. 2 and 3 are single-slope PWM with top fixed at 255 (mode 2) or equal to the A compare value (mode 3). 4 and 5 are dual-slope, buffered at top. 6 and 7 are dual-slope, buffered at bottom. In the dual-slope pairs, the odd code takes top from the A compare value and the even code uses 255. In modes 0 to 3, a tick with `count` at top loads 0; any other tick adds 1. `count` never changes without a tick or a write.
- R3: In modes 4 to 7, the count rises to top and then falls to 0. The direction flips on the same tick that makes the count reach top or 0.
- R4: A tick with `count` equal to a channel's compare value raises that channel's flag for exactly the next cycle. A force strobe raises no flag and leaves `count` unchanged, even in mode 1.
- R5: Output mode 00 deasserts the pin enable in every timer mode. While the enable is low, no tick changes the pin.
- R6: In modes 0 and 1, a compare match applies the output mode: 01 toggles the pin, 10 drives it to 0, 11 drives it to 1.
- R7: In modes 2 and 3, output mode 10 drives the pin to 1 on a tick at count 0 and to 0 on a match. Output mode 11 does the reverse. If the match also falls at count 0, the match action wins.
- R8: In modes 4 to 7, output mode 10 drives the pin to 0 on a match while rising and to 1 on a match while falling. Output mode 11 does the reverse.
- R9: In PWM modes (2 to 7), output mode 01 toggles pin A on each match only when the mode takes top from the A compare value (odd code). Channel B with 01 is disconnected. Channel A with 01 in an even PWM mode is disconnected.
- R10: In PWM modes, when a channel's compare value equals top and its output mode is 10 or 11, matches do not change the pin. On a tick at count 0, the pin goes to 1 for mode 10 and to 0 for mode 11.
- R11: Control bits 7 (A) and 8 (B) are force strobes. In modes 0 and 1, a strobe applies the action of the output mode being written. In modes 2 to 7, the strobe has no effect on the pin.
- R12: In modes 0 and 1, a compare write takes effect at once. In modes 2 to 5, it takes effect on the tick at top. In modes 6 and 7, it takes effect on the tick at count 0.
- R13: Write select codes are as follows. 0 selects the control word (bits 2:0 timer mode, bits 4:3 output mode A, bits 6:5 output mode B, bits 8:7 strobes). 1 selects compare A and 2 selects compare B. 3 loads `count`; this load takes priority over a tick and keeps the count direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count enable, one count step per high cycle |
| count | output | 16 | Current count |
| wave_a | output | 1 | Channel A pin level |
| wave_a_en | output | 1 | Channel A owns its pin |
| wave_b | output | 1 | Channel B pin level |
| wave_b_en | output | 1 | Channel B owns its pin |
| irq_a | output | 1 | Channel A compare-match flag |
| irq_b | output | 1 | Channel B compare-match flag |

## Verification
The assertions check on every cycle that nothing moves without a cause. The count and both pins hold when there is neither a tick nor a write. A disconnected pin stays put. Every flag follows a tick. Channel B never owns its pin with toggle mode in a PWM mode. The directed scenarios are the only place the actual waveform levels are visible. They cover the set and clear points in each slope, the reversal at top and bottom, the compare-equals-top case and the moment a buffered compare value becomes active. They also show that a force strobe leaves the count and flags alone.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [2:0] {
        TM_FREE    = 3'd0,
        TM_CLRM    = 3'd1,
        TM_SS_FIX  = 3'd2,
        TM_SS_A    = 3'd3,
        TM_DST_FIX = 3'd4,
        TM_DST_A   = 3'd5,
        TM_DSB_FIX = 3'd6,
        TM_DSB_A   = 3'd7
    } tmode_e;

    typedef enum logic [1:0] {
        OM_OFF = 2'd0,
        OM_TGL = 2'd1,
        OM_LO  = 2'd2,
        OM_HI  = 2'd3
    } omode_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMPA = 2'd1;
    localparam logic [1:0] SEL_CMPB = 2'd2;
    localparam logic [1:0] SEL_CNT  = 2'd3;

    function automatic logic f_pwm(input tmode_e m);
        return m[2] | m[1];
    endfunction

    function automatic logic f_dual(input tmode_e m);
        return m[2];
    endfunction

    function automatic logic f_top_a(input tmode_e m);
        return m[0];
    endfunction

    function automatic logic f_buf_bottom(input tmode_e m);
        return m[2] & m[1];
    endfunction

    function automatic logic f_apply(input omode_e om, input logic pin);
        case (om)
            OM_TGL:  return ~pin;
            OM_LO:   return 1'b0;
            OM_HI:   return 1'b1;
            default: return pin;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cmp_count.sv
module tmr_cmp_count
    import tmr_cmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  tmode_e        mode,
    input  logic [CW-1:0] top,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          down,
    output logic          at_top,
    output logic          at_bot
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CW:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = {1'b0, st_q.cnt} + 1'b1;
        if (!f_dual(mode)) begin
            st_d.down = 1'b0;
        end
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (!f_dual(mode)) begin
                st_d.cnt = (st_q.cnt == top) ? '0 : inc[CW-1:0];
            end else if (!st_q.down) begin
                if (inc >= {1'b0, top}) begin
                    st_d.cnt  = top;
                    st_d.down = 1'b1;
                end else begin
                    st_d.cnt = inc[CW-1:0];
                end
            end else begin
                if (st_q.cnt <= CW'(1)) begin
                    st_d.cnt  = '0;
                    st_d.down = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign down   = st_q.down;
    assign at_top = tick && (st_q.cnt == top);
    assign at_bot = tick && (st_q.cnt == '0);

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_cmp_pkg::*;
#(
    parameter int CW   = 16,
    parameter bit IS_A = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmode_e        mode,
    input  omode_e        om,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] top,
    input  logic          down,
    input  logic          force_s,
    input  omode_e        force_om,
    output logic          pin,
    output logic          pin_en,
    output logic          flag
);

    typedef struct packed {
        logic pin;
        logic flag;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   conn, match, bot;

    always_comb begin
        conn  = (om != OM_OFF) &&
                ((om != OM_TGL) || !f_pwm(mode) || (IS_A && f_top_a(mode)));
        match = tick && (cnt == cmp);
        bot   = tick && (cnt == '0);
        st_d      = st_q;
        st_d.flag = match;
        if (conn) begin
            if (!f_pwm(mode)) begin
                if (match) st_d.pin = f_apply(om, st_q.pin);
            end else if (om == OM_TGL) begin
                if (match) st_d.pin = ~st_q.pin;
            end else if (cmp == top) begin
                if (bot) st_d.pin = (om == OM_LO);
            end else if (!f_dual(mode)) begin
                if (bot)   st_d.pin = (om == OM_LO);
                if (match) st_d.pin = (om == OM_HI);
            end else if (match) begin
                st_d.pin = down ? (om == OM_LO) : (om == OM_HI);
            end
        end
        if (force_s) begin
            st_d.pin = f_apply(force_om, st_d.pin);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin    = st_q.pin;
    assign pin_en = conn;
    assign flag   = st_q.flag;

endmodule

// File: rtl/tmr_cmp_wave.sv
module tmr_cmp_wave
    import tmr_cmp_pkg::*;
#(
    parameter int CW        = 16,
    parameter int FIXED_TOP = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          wave_a,
    output logic          wave_a_en,
    output logic          wave_b,
    output logic          wave_b_en,
    output logic          irq_a,
    output logic          irq_b
);

    localparam int            NCH       = 2;
    localparam logic [CW-1:0] FIX_TOP_V = CW'(FIXED_TOP);

    typedef struct packed {
        tmode_e        mode;
        omode_e        om_a;
        omode_e        om_b;
        logic [CW-1:0] buf_a;
        logic [CW-1:0] buf_b;
        logic [CW-1:0] act_a;
        logic [CW-1:0] act_b;
    } regs_t;

    regs_t          r_d, r_q;
    tmode_e         wr_mode;
    logic           load, upd, at_top, at_bot, down;
    logic [CW-1:0]  top_val, cnt;
    logic [NCH-1:0] force_v, pin_v, en_v, flag_v;
    omode_e         om_v  [NCH];
    omode_e         fom_v [NCH];
    logic [CW-1:0]  cmp_v [NCH];
    tmode_e         mode_q;
    omode_e         om_b_q;

    always_comb begin
        if (r_q.mode == TM_FREE)     top_val = '1;
        else if (f_top_a(r_q.mode))  top_val = r_q.act_a;
        else                         top_val = FIX_TOP_V;
    end

    always_comb begin
        r_d      = r_q;
        load     = 1'b0;
        force_v  = '0;
        wr_mode  = tmode_e'(wr_data[2:0]);
        fom_v[0] = omode_e'(wr_data[4:3]);
        fom_v[1] = omode_e'(wr_data[6:5]);
        upd      = f_buf_bottom(r_q.mode) ? at_bot : at_top;
        if (f_pwm(r_q.mode) && upd) begin
            r_d.act_a = r_q.buf_a;
            r_d.act_b = r_q.buf_b;
        end
        if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: begin
                    r_d.mode   = wr_mode;
                    r_d.om_a   = fom_v[0];
                    r_d.om_b   = fom_v[1];
                    force_v[0] = wr_data[7] && !f_pwm(wr_mode);
                    force_v[1] = wr_data[8] && !f_pwm(wr_mode);
                end
                SEL_CMPA: begin
                    r_d.buf_a = wr_data;
                    if (!f_pwm(r_q.mode)) r_d.act_a = wr_data;
                end
                SEL_CMPB: begin
                    r_d.buf_b = wr_data;
                    if (!f_pwm(r_q.mode)) r_d.act_b = wr_data;
                end
                default: load = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    tmr_cmp_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (r_q.mode),
        .top      (top_val),
        .load     (load),
        .load_val (wr_data),
        .cnt      (cnt),
        .down     (down),
        .at_top   (at_top),
        .at_bot   (at_bot)
    );

    assign om_v[0]  = r_q.om_a;
    assign om_v[1]  = r_q.om_b;
    assign cmp_v[0] = r_q.act_a;
    assign cmp_v[1] = r_q.act_b;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_cmp_chan #(.CW(CW), .IS_A(i == 0)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (r_q.mode),
            .om       (om_v[i]),
            .tick     (tick),
            .cnt      (cnt),
            .cmp      (cmp_v[i]),
            .top      (top_val),
            .down     (down),
            .force_s  (force_v[i]),
            .force_om (fom_v[i]),
            .pin      (pin_v[i]),
            .pin_en   (en_v[i]),
            .flag     (flag_v[i])
        );
    end

    assign mode_q    = r_q.mode;
    assign om_b_q    = r_q.om_b;
    assign count     = cnt;
    assign wave_a    = pin_v[0];
    assign wave_b    = pin_v[1];
    assign wave_a_en = en_v[0];
    assign wave_b_en = en_v[1];
    assign irq_a     = flag_v[0];
    assign irq_b     = flag_v[1];

endmodule

// File: rtl/tmr_cmp_wave_chk.sv
module tmr_cmp_wave_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          wr_en,
    input logic [CW-1:0] count,
    input logic          wave_a,
    input logic          wave_b,
    input logic          wave_a_en,
    input logic          wave_b_en,
    input logic          irq_a,
    input logic          irq_b,
    input logic [2:0]    mode,
    input logic [1:0]    om_b
);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));

    // R6 R11
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(wave_a) && $stable(wave_b)));

    // R5
    disc_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_a_en && !wr_en) |=> $stable(wave_a));

    // R5
    disc_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_b_en && !wr_en) |=> $stable(wave_b));

    // R4
    flag_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |-> $past(tick));

    // R9
    b_toggle_pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode >= 3'd2) && (om_b == 2'd1)) |-> !wave_b_en);

endmodule

bind tmr_cmp_wave tmr_cmp_wave_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .count     (count),
    .wave_a    (wave_a),
    .wave_b    (wave_b),
    .wave_a_en (wave_a_en),
    .wave_b_en (wave_b_en),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .mode      (mode_q),
    .om_b      (om_b_q)
);

// File: tb/tmr_cmp_wave_tb.sv
`timescale 1ns/1ps
module tmr_cmp_wave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tick = 1'b0;
    logic [15:0] count;
    logic        wave_a, wave_a_en, wave_b, wave_b_en, irq_a, irq_b;
    int          total = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    tmr_cmp_wave u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .count(count),
        .wave_a(wave_a), .wave_a_en(wave_a_en), .wave_b(wave_b),
        .wave_b_en(wave_b_en), .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [15:0] cw(input logic [2:0] m, input logic [1:0] oa,
                                       input logic [1:0] ob, input logic fa,
                                       input logic fb);
        return {7'd0, fb, fa, ob, oa, m};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 pins", {wave_a, wave_b}, 0);
        chk("R1 enables", {wave_a_en, wave_b_en}, 0);
        chk("R1 flags", {irq_a, irq_b}, 0);
    endtask

    task automatic t_nonpwm();
        wr(2'd0, cw(3'd0, 2'd2, 2'd3, 1'b1, 1'b1));
        chk("R11 force clear A", wave_a, 0);
        chk("R11 force set B", wave_b, 1);
        wr(2'd0, cw(3'd0, 2'd1, 2'd2, 1'b0, 1'b0));
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd0);
        ticks(2);
        chk("R6 B before match", wave_b, 1);
        ticks(1);
        chk("R6 B cleared on match", wave_b, 0);
        chk("R6 A before match", wave_a, 0);
        ticks(1);
        chk("R6 A toggled on match", wave_a, 1);
        chk("R2 free count", count, 4);
        chk("R4 flag A pulse", irq_a, 1);
        @(negedge clk);
        chk("R4 flag A one cycle", irq_a, 0);
        chk("R2 count holds without tick", count, 4);
    endtask

    task automatic t_ctc_force();
        wr(2'd3, 16'd0);
        wr(2'd0, cw(3'd1, 2'd0, 2'd0, 1'b0, 1'b0));
        wr(2'd1, 16'd4);
        ticks(5);
        chk("R2 clear-on-match wrap", count, 0);
        ticks(1);
        chk("R2 clear-on-match restart", count, 1);
        wr(2'd0, cw(3'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        wr(2'd3, 16'hFFFE);
        ticks(2);
        chk("R2 free-running wrap", count, 0);
        wr(2'd0, cw(3'd1, 2'd2, 2'd0, 1'b1, 1'b0));
        chk("R11 force clear in mode 1", wave_a, 0);
        wr(2'd3, 16'd2);
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = cw(3'd1, 2'd3, 2'd0, 1'b1, 1'b0);
        @(negedge clk); wr_en = 1'b0;
        chk("R11 force set in mode 1", wave_a, 1);
        chk("R4 force no flag", irq_a, 0);
        chk("R4 force keeps count", count, 2);
        @(negedge clk);
        chk("R4 force no flag later", irq_a, 0);
    endtask

    task automatic t_fast();
        wr(2'd0, cw(3'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd0);
        wr(2'd0, cw(3'd2, 2'd2, 2'd3, 1'b0, 1'b0));
        ticks(1);
        chk("R7 mode 10 set at bottom", wave_a, 1);
        chk("R7 mode 11 clear at bottom", wave_b, 0);
        ticks(3);
        chk("R7 mode 10 clear on match", wave_a, 0);
        chk("R7 mode 11 set on match", wave_b, 1);
        wr(2'd2, 16'd10);
        wr(2'd3, 16'd0);
        ticks(4);
        chk("R12 buffered value not yet active", wave_b, 1);
        wr(2'd3, 16'd254);
        ticks(2);
        chk("R2 fixed top wrap", count, 0);
        ticks(1);
        chk("R7 B cleared at bottom", wave_b, 0);
        ticks(9);
        chk("R12 old compare gone", wave_b, 0);
        ticks(1);
        chk("R12 new compare active after top", wave_b, 1);
        chk("R12 count", count, 11);
        wr(2'd0, cw(3'd2, 2'd3, 2'd3, 1'b1, 1'b0));
        chk("R11 force ignored in PWM", wave_a, 0);
        chk("R11 enable in PWM", wave_a_en, 1);
    endtask

    task automatic t_dual_top();
        wr(2'd0, cw(3'd0, 2'd3, 2'd0, 1'b1, 1'b0));
        wr(2'd1, 16'd3);
        wr(2'd3, 16'd0);
        wr(2'd0, cw(3'd4, 2'd2, 2'd0, 1'b0, 1'b0));
        ticks(4);
        chk("R8 clear on rising match", wave_a, 0);
        wr(2'd3, 16'd250);
        ticks(5);
        chk("R3 reaches top", count, 255);
        ticks(1);
        chk("R3 falls after top", count, 254);
        wr(2'd3, 16'd4);
        ticks(2);
        chk("R8 set on falling match", wave_a, 1);
        chk("R13 load keeps direction", count, 2);
        ticks(2);
        chk("R3 reaches bottom", count, 0);
        ticks(1);
        chk("R3 rises after bottom", count, 1);
    endtask

    task automatic t_dual_bot();
        wr(2'd0, cw(3'd0, 2'd0, 2'd3, 1'b0, 1'b1));
        wr(2'd2, 16'd5);
        wr(2'd0, cw(3'd6, 2'd0, 2'd3, 1'b0, 1'b0));
        wr(2'd2, 16'd8);
        wr(2'd3, 16'd254);
        ticks(1);
        chk("R3 fixed top turn", count, 255);
        ticks(1);
        wr(2'd3, 16'd9);
        ticks(2);
        chk("R12 no update at top in modes 6-7", wave_b, 1);
        ticks(3);
        chk("R8 mode 11 clear on falling match", wave_b, 0);
        ticks(5);
        chk("R3 bottom turn", count, 1);
        ticks(7);
        chk("R12 before new match", wave_b, 0);
        ticks(1);
        chk("R12 update at bottom, R8 rising set", wave_b, 1);
    endtask

    task automatic t_toggle_pwm();
        wr(2'd0, cw(3'd0, 2'd2, 2'd0, 1'b1, 1'b0));
        wr(2'd1, 16'd5);
        wr(2'd3, 16'd0);
        wr(2'd0, cw(3'd3, 2'd1, 2'd1, 1'b0, 1'b0));
        chk("R9 A enabled with top from A", wave_a_en, 1);
        chk("R9 B disconnected", wave_b_en, 0);
        ticks(6);
        chk("R9 top from A wrap", count, 0);
        chk("R9 A toggled", wave_a, 1);
        ticks(6);
        chk("R9 A toggled back", wave_a, 0);
        wr(2'd0, cw(3'd2, 2'd1, 2'd0, 1'b0, 1'b0));
        chk("R9 A disconnected with fixed top", wave_a_en, 0);
        wr(2'd3, 16'd0);
        ticks(6);
        chk("R9 A not toggled with fixed top", wave_a, 0);
    endtask

    task automatic t_special();
        wr(2'd0, cw(3'd0, 2'd2, 2'd3, 1'b1, 1'b1));
        wr(2'd1, 16'd6);
        wr(2'd2, 16'd6);
        wr(2'd3, 16'd0);
        wr(2'd0, cw(3'd3, 2'd2, 2'd3, 1'b0, 1'b0));
        ticks(1);
        chk("R10 mode 10 high at bottom", wave_a, 1);
        chk("R10 mode 11 low at bottom", wave_b, 0);
        ticks(6);
        chk("R10 wrap", count, 0);
        chk("R10 A match at top ignored", wave_a, 1);
        chk("R10 B match at top ignored", wave_b, 0);
    endtask

    task automatic t_disc();
        logic va;
        wr(2'd0, cw(3'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        chk("R5 enables low", {wave_a_en, wave_b_en}, 0);
        va = wave_a;
        wr(2'd1, 16'd2);
        wr(2'd3, 16'd0);
        ticks(4);
        chk("R5 pin holds when disconnected", wave_a, va);
        wr(2'd0, cw(3'd5, 2'd0, 2'd0, 1'b0, 1'b0));
        chk("R5 disconnected in dual mode", wave_a_en, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nonpwm();
        t_ctc_force();
        t_fast();
        t_dual_top();
        t_dual_bot();
        t_toggle_pwm();
        t_special();
        t_disc();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule